// File: doc/BRIEF.md
# Two-Wire Bus Unstick Sequencer

This block recovers a two-wire serial bus whose data line is held low by a slave that lost track of a transfer. It owns two line-override controls, one for the clock line and one for the data line; a set override pulls its line low. A one-cycle start pulse makes the sequencer toggle the clock override through nine full clock pulses. Those pulses let the stuck slave shift out the rest of its byte. The sequencer then synthesises a STOP condition by pulling data low, releasing the clock and finally releasing both lines. Every step lasts the same programmable time, counted in clock cycles from a microsecond tick length. A one-cycle done pulse marks the end.

The same block holds a small 12-bit status/override register. That register carries three interrupt status flags, the two override bits, and the live state of both bus lines. Software may write the override bits directly while the sequencer is idle. While a recovery runs, the sequencer owns those bits.

Top module: `bus_unstick_seq`

## Requirements
- R1: After reset both override outputs are 0, the interrupt flags read 0, and busy and done are 0.
- R2: The register reads as follows: bits 2:0 hold the interrupt flags, bit 8 the data override, bit 9 the clock override, bit 10 the live data line input, bit 11 the live clock line input. All other bits read 0.
- R3: An override bit of 1 drives its line-low output to 1. The data override is bit 8 and drives sda_low_o. The clock override is bit 9 and drives scl_low_o.
- R4: A recovery starts with 18 steps. The clock override is 0 in the even steps and 1 in the odd steps, and the data override stays 0 throughout, giving nine clock pulses.
- R5: Every step holds its override values for exactly CLK_PER_US*STEP_US cycles. Step 0 takes effect at the clock edge that captures start_i.
- R6: After the pulses, three tail steps follow. First both overrides are 1. Then the data override is 1 and the clock override is 0. Last, both are 0.
- R7: done_o is high for exactly one cycle, at the end of the last step's hold. busy_o falls at the same edge.
- R8: A start pulse that arrives while busy_o is high has no effect on the running sequence or its end time.
- R9: A register write updates bits 9:8 only while the sequencer is idle. While busy, such writes are ignored.
- R10: A 1 on irq_set_i[n] sets flag n. Writing 1 to register bit n clears that flag. If a set and a clear hit the same flag in the same cycle, the set wins.
- R11: Register bits 10 and 11 follow sda_in_i and scl_in_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin recovery |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 12 | Register write data |
| reg_rdata_o | output | 12 | Register read value |
| irq_set_i | input | 3 | Per-flag interrupt set pulses |
| sda_in_i | input | 1 | Sampled data line level |
| scl_in_i | input | 1 | Sampled clock line level |
| sda_low_o | output | 1 | Pull data line low |
| scl_low_o | output | 1 | Pull clock line low |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | One-cycle end-of-recovery pulse |

## Verification
The bench walks the expected override pair through all 21 steps. It probes both sides of the first step boundary, so an off-by-one step length or a pulse-count error shows up as a wrong pair in some step. In the middle of a run it issues a start together with an override write. A design that restarted on the start would end late or show step 0 again. A design that let the write through would show both lines pulled low. The bench checks the exact cycle of the done pulse, which exposes an extra or missing step. It also checks flag set/clear collisions, which a clear-priority design would lose.

// File: rtl/bus_unstick_seq.sv
module bus_unstick_seq #(
  parameter int CLK_PER_US = 250,
  parameter int STEP_US    = 5,
  parameter int PULSES     = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        reg_we_i,
  input  logic [11:0] reg_wdata_i,
  output logic [11:0] reg_rdata_o,
  input  logic [2:0]  irq_set_i,
  input  logic        sda_in_i,
  input  logic        scl_in_i,
  output logic        sda_low_o,
  output logic        scl_low_o,
  output logic        busy_o,
  output logic        done_o
);
  localparam int STEP_CYC   = CLK_PER_US * STEP_US;
  localparam int CW         = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam int PULSE_STEP = 2 * PULSES;
  localparam int LAST_STEP  = PULSE_STEP + 2;
  localparam int SW         = $clog2(LAST_STEP + 1);

  logic [CW-1:0] cnt;
  logic [SW-1:0] step;
  logic          busy, done, ovr_sda, ovr_scl;
  logic [2:0]    irq_q;
  logic          unused_wbits;

  assign unused_wbits = ^{reg_wdata_i[11:10], reg_wdata_i[7:3]};

  function automatic logic [1:0] ovr_of(input logic [SW-1:0] s);
    if (int'(s) < PULSE_STEP)          return {1'b0, s[0]};
    else if (int'(s) == PULSE_STEP)    return 2'b11;
    else if (int'(s) == PULSE_STEP+1)  return 2'b10;
    else                               return 2'b00;
  endfunction

  wire step_end = (int'(cnt) == STEP_CYC - 1);
  wire last     = (int'(step) == LAST_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      step    <= '0;
      cnt     <= '0;
      ovr_sda <= 1'b0;
      ovr_scl <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start_i) begin
          busy                <= 1'b1;
          step                <= '0;
          cnt                 <= '0;
          {ovr_sda, ovr_scl}  <= ovr_of('0);
        end else if (reg_we_i) begin
          {ovr_scl, ovr_sda}  <= reg_wdata_i[9:8];
        end
      end else if (step_end) begin
        cnt <= '0;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          step               <= step + 1'b1;
          {ovr_sda, ovr_scl} <= ovr_of(step + 1'b1);
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= (irq_q & ~(reg_we_i ? reg_wdata_i[2:0] : 3'b000)) | irq_set_i;
  end

  assign reg_rdata_o = {scl_in_i, sda_in_i, ovr_scl, ovr_sda, 5'b00000, irq_q};
  assign sda_low_o   = ovr_sda;
  assign scl_low_o   = ovr_scl;
  assign busy_o      = busy;
  assign done_o      = done;

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  // R5
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt != '0 |-> $stable({ovr_sda, ovr_scl}));
  // R8
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start_i && step != '0 |=> step != '0);
  // R4
  pulse_sda_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && int'(step) < PULSE_STEP |-> !ovr_sda);
  // R6
  tail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && last |-> !ovr_sda && !ovr_scl);
  // R10
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set_i[0] |=> irq_q[0]);
endmodule

// File: tb/sim_bus_unstick_seq.sv
`timescale 1ns/1ps
module sim_bus_unstick_seq;
  localparam int CPU = 2, SUS = 5, S = CPU * SUS, NSTEP = 21;
  // expected {sda_low, scl_low} per step
  localparam logic [1:0] EXP [NSTEP] = '{
    2'b00, 2'b01, 2'b00, 2'b01, 2'b00, 2'b01, 2'b00, 2'b01, 2'b00, 2'b01,
    2'b00, 2'b01, 2'b00, 2'b01, 2'b00, 2'b01, 2'b00, 2'b01,
    2'b11, 2'b10, 2'b00};

  logic clk = 0, rst_n = 0, start = 0, we = 0, sda_in = 1, scl_in = 1;
  logic [11:0] wdata = 0, rdata;
  logic [2:0] irq_set = 0;
  logic sda_low, scl_low, busy, done;
  int n_chk = 0, n_fail = 0, t = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bus_unstick_seq #(.CLK_PER_US(CPU), .STEP_US(SUS), .PULSES(9)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_set_i(irq_set), .sda_in_i(sda_in), .scl_in_i(scl_in),
    .sda_low_o(sda_low), .scl_low_o(scl_low), .busy_o(busy), .done_o(done));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic advance_to(input int target);
    while (t < target) begin @(negedge clk); t++; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {sda_low, scl_low, busy, done, rdata[9:8], rdata[2:0]}, 0);
    rst_n = 1;
    @(negedge clk);
    // R2/R11 live line bits and reserved zeros
    sda_in = 0; scl_in = 1; #1;
    check("R11", rdata[11:10], 2'b10);
    check("R2", {rdata[7:3]}, 0);
    sda_in = 1; scl_in = 0; #1;
    check("R11", rdata[11:10], 2'b01);
    // R10 flags
    irq_set = 3'b101; @(negedge clk); irq_set = 0;
    check("R10", rdata[2:0], 3'b101);
    we = 1; wdata = 12'h001; @(negedge clk); we = 0;
    check("R10", rdata[2:0], 3'b100);
    we = 1; wdata = 12'h002; irq_set = 3'b010; @(negedge clk); we = 0; irq_set = 0;
    check("R10", rdata[2:0], 3'b110);
    // R9/R3 idle writes reach the overrides
    we = 1; wdata = 12'h300; @(negedge clk); we = 0;
    check("R9", rdata[9:8], 2'b11);
    check("R3", {sda_low, scl_low}, 2'b11);
    we = 1; wdata = 12'h100; @(negedge clk); we = 0;
    check("R3", {sda_low, scl_low}, 2'b10);
    // launch recovery; t=0 is the negedge after the capturing edge
    start = 1; @(negedge clk); start = 0; t = 0;
    check("R7", busy, 1);
    for (int k = 0; k < NSTEP; k++) begin
      advance_to(k * S + S / 2);
      check(k < 18 ? "R4" : "R6", {sda_low, scl_low}, EXP[k]);
      check("R2", rdata[9:8], {EXP[k][0], EXP[k][1]});
      if (k == 0) begin
        advance_to(S - 1); check("R5", {sda_low, scl_low}, EXP[0]);
        advance_to(S);     check("R5", {sda_low, scl_low}, EXP[1]);
      end
      if (k == 5) begin
        start = 1; we = 1; wdata = 12'h300;
        @(negedge clk); t++; start = 0; we = 0;
        check("R9", {sda_low, scl_low}, EXP[5]);
      end
    end
    advance_to(NSTEP * S - 1);
    check("R8", {busy, done}, 2'b10);
    advance_to(NSTEP * S);
    check("R7", {busy, done}, 2'b01);
    advance_to(NSTEP * S + 1);
    check("R7", {busy, done}, 2'b00);
    check("R6", {sda_low, scl_low}, 2'b00);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule